// File: doc/BRIEF.md
# Bus-Snooping Watchdog Timer

This block is a watchdog timer with no dedicated service pin. It watches the data and clock lines of a two-wire serial bus. It restarts its countdown each time a complete framed transaction ends on that bus. A transaction counts whatever device it is addressed to, so any normal read or write by the host processor serves as proof that the processor is alive.

When no such transaction arrives within the selected period, an active-low watchdog output goes low. It stays low until the bus shows activity again or software rewrites the period setting.

A two-bit setting, loaded through a one-cycle parallel write strobe, picks one of three period lengths or turns the watchdog off. The countdown runs on a prescaled tick derived from the system clock. The prescale ratio and the three period lengths are parameters.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, `wd_n` is high, the period setting is 00, and the countdown starts from zero.
- R2: A START is SDA going from 1 to 0 while SCL stays 1. A STOP is SDA going from 0 to 1 while SCL stays 1. Both lines pass through a two-flop synchronizer before these edges are detected.
- R3: A START, then at least one SCL fall and a later SCL rise, then a STOP, restarts the countdown and releases `wd_n` high. No address or data content is examined.
- R4: A START followed directly by a STOP, with no SCL low-then-high cycle in between, does not restart the countdown.
- R5: For setting 00, 01 and 10, `wd_n` falls after PERIOD0, PERIOD1 and PERIOD2 ticks respectively. One tick is PRESCALE system clocks, counted from the last restart.
- R6: Setting 11 disables the watchdog, and `wd_n` stays high for as long as that setting is held.
- R7: A write through `cfg_we` loads `cfg_data` as the new setting, restarts the countdown and releases `wd_n` high.
- R8: Once low, `wd_n` stays low until a qualifying bus sequence (R3), a setting write (R7) or a reset occurs.
- R9: The restart triggered by a STOP takes effect on the fourth rising clock edge after the STOP edge appears at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Serial data line, asynchronous to clk |
| scl_in | input | 1 | Serial clock line, asynchronous to clk |
| cfg_we | input | 1 | One-cycle strobe that loads the period setting |
| cfg_data | input | 2 | Period setting: 00, 01, 10 pick a period; 11 disables |
| wd_n | output | 1 | Active-low watchdog expiry output |

## Verification
Each period setting is tried with three bus patterns placed mid-period: an idle bus, a full framed sequence, and a bare START/STOP pair. The idle bus shows where each period ends, sampled a few cycles before and after the expected edge. The framed sequence shows that the restart happens and that it counts from the STOP. The bare pair shows that the framing qualifier is enforced. Directed cases then cover the disabled setting over a long idle stretch, the output staying low over a long expired stretch, and release from expiry both by bus activity and by a setting write.

// File: rtl/wd_pkg.sv
package wd_pkg;
   typedef enum logic [1:0] {
      WD_SHORT = 2'b00,
      WD_MID   = 2'b01,
      WD_LONG  = 2'b10,
      WD_OFF   = 2'b11
   } wd_mode_e;
endpackage

// File: rtl/wd_sync2.sv
module wd_sync2 #(
   parameter int          WIDTH    = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("wd_sync2: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic meta;
      logic stable;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta   <= RST_VAL[i];
            stable <= RST_VAL[i];
         end else begin
            meta   <= d[i];
            stable <= meta;
         end
      end
      assign q[i] = stable;
   end
endmodule

// File: rtl/wd_bus_monitor.sv
module wd_bus_monitor (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_s,
   input  logic scl_s,
   output logic kick
);
   logic sda_d, scl_d;
   logic in_frame, seen_low, seen_high;
   logic start_c, stop_c, scl_fall, scl_rise;

   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_fall = scl_d & ~scl_s;
   assign scl_rise = ~scl_d & scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_d     <= 1'b1;
         scl_d     <= 1'b1;
         in_frame  <= 1'b0;
         seen_low  <= 1'b0;
         seen_high <= 1'b0;
         kick      <= 1'b0;
      end else begin
         sda_d <= sda_s;
         scl_d <= scl_s;
         kick  <= 1'b0;
         if (start_c) begin
            in_frame  <= 1'b1;
            seen_low  <= 1'b0;
            seen_high <= 1'b0;
         end else if (stop_c) begin
            kick      <= in_frame & seen_high;
            in_frame  <= 1'b0;
            seen_low  <= 1'b0;
            seen_high <= 1'b0;
         end else if (in_frame) begin
            if (scl_fall) seen_low <= 1'b1;
            if (scl_rise && seen_low) seen_high <= 1'b1;
         end
      end
   end

   // R4
   bare_pair_no_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_c && !seen_high) |=> !kick);

   // R3
   kick_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |-> $past(in_frame));
endmodule

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("wd_tick_gen: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_direct
      assign tick = ~clear;
   end else begin : g_divide
      logic [PW-1:0] div;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          div <= '0;
         else if (clear)                      div <= '0;
         else if (div == PW'(PRESCALE - 1))   div <= '0;
         else                                 div <= div + 1'b1;
      end
      assign tick = !clear && (div == PW'(PRESCALE - 1));
   end
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
   parameter int PRESCALE = 1024,
   parameter int PERIOD0  = 1000,
   parameter int PERIOD1  = 4000,
   parameter int PERIOD2  = 16000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_in,
   input  logic       scl_in,
   input  logic       cfg_we,
   input  logic [1:0] cfg_data,
   output logic       wd_n
);
   import wd_pkg::*;

   localparam int CNT_W = $clog2(PERIOD2 + 1);

   if (PERIOD0 < 2 || PERIOD1 <= PERIOD0 || PERIOD2 <= PERIOD1) begin : g_bad_periods
      $error("bus_watchdog: periods must satisfy 2 <= PERIOD0 < PERIOD1 < PERIOD2");
   end

   logic [1:0]       line_s;
   logic             kick, tick, restart, expired;
   wd_mode_e         mode;
   logic [CNT_W-1:0] cnt, limit;

   wd_sync2 #(.WIDTH(2), .RST_VAL(2'b11)) i_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s));

   wd_bus_monitor i_mon (
      .clk(clk), .rst_n(rst_n), .sda_s(line_s[0]), .scl_s(line_s[1]), .kick(kick));

   assign restart = kick | cfg_we;

   wd_tick_gen #(.PRESCALE(PRESCALE)) i_tick (
      .clk(clk), .rst_n(rst_n), .clear(restart || mode == WD_OFF), .tick(tick));

   always_comb begin
      case (mode)
         WD_SHORT: limit = CNT_W'(PERIOD0);
         WD_MID:   limit = CNT_W'(PERIOD1);
         default:  limit = CNT_W'(PERIOD2);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= WD_SHORT;
         cnt     <= '0;
         expired <= 1'b0;
      end else begin
         if (cfg_we) mode <= wd_mode_e'(cfg_data);
         if (restart || mode == WD_OFF) begin
            cnt     <= '0;
            expired <= 1'b0;
         end else if (tick && !expired) begin
            if (cnt == limit - 1'b1) begin
               cnt     <= '0;
               expired <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign wd_n = ~expired;

   // R7
   restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (wd_n && cnt == '0));

   // R6
   disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WD_OFF && $past(mode == WD_OFF)) |-> wd_n);

   // R5
   expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_n) |-> $past(tick));

   // R8
   expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_n && !restart) |=> !wd_n);
endmodule

// File: tb/test_bus_watchdog.sv
module test_bus_watchdog;
   localparam int PRE = 4, P0 = 8, P1 = 16, P2 = 32;
   localparam int NV = 12;
   // fields: mode, action (0 idle, 1 framed, 2 bare pair), wait after action, expected wd_n
   localparam int VEC [NV][4] = '{
      '{0, 0,   8, 0}, '{0, 1,   8, 1}, '{0, 1,  40, 0}, '{0, 2,   8, 0},
      '{1, 0,  30, 1}, '{1, 0,  40, 0}, '{1, 1,  60, 1}, '{2, 0,  90, 1},
      '{2, 0, 110, 0}, '{2, 2, 110, 0}, '{3, 0, 300, 1}, '{3, 2,  10, 1}};

   logic clk = 0, rst_n = 0, sda = 1, scl = 1, cfg_we = 0;
   logic [1:0] cfg_data = 2'b00;
   logic wd_n;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   bus_watchdog #(.PRESCALE(PRE), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2)) i_bus_watchdog (
      .clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl),
      .cfg_we(cfg_we), .cfg_data(cfg_data), .wd_n(wd_n));

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(logic exp, string req);
      checks++;
      if (wd_n !== exp) begin
         errors++;
         $display("FAIL %s: wd_n=%b expected %b at %0t", req, wd_n, exp, $time);
      end
   endtask

   task automatic write_cfg(logic [1:0] m);
      @(negedge clk); cfg_we = 1; cfg_data = m;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic bus_action(int kind);
      if (kind == 1) begin
         sda = 0; wait_n(3); scl = 0; wait_n(3);
         scl = 1; wait_n(3); sda = 1; wait_n(3);
      end else if (kind == 2) begin
         sda = 0; wait_n(3); sda = 1; wait_n(9);
      end else begin
         wait_n(12);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_n(3); rst_n = 1;
      check(1'b1, "R1 reset state");
      wait_n(P0 * PRE - 8);
      check(1'b1, "R1 default period before end");
      wait_n(12);
      check(1'b0, "R1/R5 default setting 00 expiry");

      for (int v = 0; v < NV; v++) begin
         write_cfg(VEC[v][0][1:0]);
         wait_n(16);
         bus_action(VEC[v][1]);
         wait_n(VEC[v][2]);
         case (VEC[v][1])
            1:       check(VEC[v][3][0], "R3/R2/R9 framed sequence");
            2:       check(VEC[v][3][0], (VEC[v][0] == 3) ? "R6 disabled" : "R4 bare pair");
            default: check(VEC[v][3][0], (VEC[v][0] == 3) ? "R6 disabled" : "R5 idle period");
         endcase
      end

      // R8: stays expired, then released by a framed sequence
      write_cfg(2'b00);
      wait_n(40);
      check(1'b0, "R8 expired");
      wait_n(100);
      check(1'b0, "R8 still expired");
      bus_action(2);
      wait_n(8);
      check(1'b0, "R8/R4 bare pair does not release");
      sda = 0; wait_n(3); scl = 0; wait_n(3); scl = 1; wait_n(3);
      sda = 1;
      wait_n(2);
      check(1'b0, "R9 not yet released two cycles after STOP");
      wait_n(3);
      check(1'b1, "R3/R9 released after STOP");

      // R7: a setting write releases an expired output
      wait_n(40);
      check(1'b0, "R7 expired before write");
      write_cfg(2'b01);
      check(1'b1, "R7 write releases output");
      wait_n(P1 * PRE - 6);
      check(1'b1, "R7 count restarted from write");

      // R6 after expiry: disable releases and holds
      wait_n(20);
      check(1'b0, "R5 setting 01 expiry");
      write_cfg(2'b11);
      wait_n(400);
      check(1'b1, "R6 disabled long idle");

      // R1: reset in the middle of expiry
      write_cfg(2'b00);
      wait_n(40);
      rst_n = 0; wait_n(2);
      check(1'b1, "R1 reset releases output");
      rst_n = 1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule